// File: doc/BRIEF.md
# Management-Bus PHY Register Model

This block models the management register set of a 10/100 Ethernet PHY as seen from a MAC. Software reaches it through one 32-bit management-frame word. Writing that word starts one access to a 16-bit PHY register. Bit 29 of the word selects a read or a write. The access completes in the same clock. On a read, the selected register's value replaces the low 16 bits of the stored word, and the word is visible on `frame_rdata` from the next cycle.

The model holds five registers: control, status, advertisement, interrupt events and interrupt enables. It returns fixed identification and capability words. It tracks a `link_up` input: each change, and the first cycle after any reset, updates two status bits and latches event flags. An interrupt line reports enabled events. A one-cycle done pulse follows every management access.

Top module: `mgmt_phy_regs`

## Requirements
- R1: After reset the registers hold these values, before the link state is applied: control 0x3000, status 0x7809, advertisement 0x01E1, enables 0x00, events 0x00. The link state is then applied in the first cycle after reset.
- R2: Applying link-up sets status bits 5 and 2 (mask 0x0024) and raises event bits 7 and 6. Applying link-down clears status mask 0x0024 and raises event bit 4. The link state is applied on every change of `link_up`.
- R3: Reads of register 2 return 0x0007, register 3 returns 0xC0D1, register 5 returns 0x0F71 and register 6 returns 0x0001. Writes to these registers change nothing.
- R4: A read of register 29 returns the event flags and clears them in the same access. An event applied in that same cycle stays set.
- R5: A write to register 0 with bit 15 set restores every register to its R1 value and then applies the current link state. Without bit 15, control becomes data & 0x7980, and data bit 12 also sets status bit 5. The control register changes only on a write.
- R6: A write to register 4 stores (data & 0x2D7F) | 0x0080. A write to register 30 stores data bits 7:0. Reads of registers 0, 1, 4 and 30 return control, status, advertisement and enables.
- R7: Addresses above 31 read as zero and ignore writes; they do not alias onto their low five bits. Registers 17, 18, 27, 31 and every other undecoded address also read as zero and ignore writes.
- R8: Frame word layout: bit 29 is 1 for a read, bits 27:18 hold the register address, bits 15:0 hold the data. After a read, `frame_rdata` holds the written bits 31:16 with the register value in bits 15:0. After a write, it holds the written word. It resets to zero.
- R9: `mgmt_done` is high for exactly the one cycle after each frame write, whether the access is a read or a write.
- R10: `irq` is the OR of (events & enables) over bits 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_we | input | 1 | Write strobe for the management-frame word; each strobe is one access |
| frame_wdata | input | FRAME_W | Management-frame word written |
| frame_rdata | output | FRAME_W | Stored management-frame word, holding the read result |
| link_up | input | 1 | Current link state, synchronous to clk |
| irq | output | 1 | Enabled-event interrupt |
| mgmt_done | output | 1 | One-cycle pulse after each access |

## Verification
The assertions assume that `link_up` and `frame_we` are synchronous to `clk` and stable around the rising edge. They also assume that a write which clears the enables is not undone by another enable write in the next cycle. The bench drives every input on the falling edge. It issues at most one frame access at a time, separated by idle cycles. It changes `link_up` only on its own, or together with a read of the event register in the dedicated same-cycle test.

// File: rtl/mgmt_phy_pkg.sv
package mgmt_phy_pkg;
   localparam int PHY_W = 16;
   localparam int IDX_W = 5;
   typedef logic [PHY_W-1:0] phy_word_t;
   typedef logic [IDX_W-1:0] phy_idx_t;

   // register indices whose positions the driver decodes
   localparam phy_idx_t RA_CTRL    = 5'd0;
   localparam phy_idx_t RA_STAT    = 5'd1;
   localparam phy_idx_t RA_ID_HI   = 5'd2;
   localparam phy_idx_t RA_ID_LO   = 5'd3;
   localparam phy_idx_t RA_ADV     = 5'd4;
   localparam phy_idx_t RA_PARTNER = 5'd5;
   localparam phy_idx_t RA_EXPAND  = 5'd6;
   localparam phy_idx_t RA_EVENT   = 5'd29;
   localparam phy_idx_t RA_EVMASK  = 5'd30;

   // reset contents
   localparam phy_word_t CTRL_INIT = 16'h3000;
   localparam phy_word_t STAT_INIT = 16'h7809;
   localparam phy_word_t ADV_INIT  = 16'h01E1;

   // constant identification / capability words
   localparam phy_word_t ID_HI_VAL   = 16'h0007;
   localparam phy_word_t ID_LO_VAL   = 16'hC0D1;
   localparam phy_word_t PARTNER_VAL = 16'h0F71;
   localparam phy_word_t EXPAND_VAL  = 16'h0001;

   // write masks and forced bits
   localparam phy_word_t CTRL_WMASK = 16'h7980;
   localparam phy_word_t ADV_WMASK  = 16'h2D7F;
   localparam phy_word_t ADV_FORCE  = 16'h0080;
   localparam phy_word_t STAT_LINK  = 16'h0024;
   localparam phy_word_t STAT_ANEG  = 16'h0020;

   localparam int CTRL_SOFT_RST_BIT = 15;
   localparam int CTRL_ANEG_EN_BIT  = 12;

   // event flag positions
   localparam int EV_ENERGY = 7;
   localparam int EV_ANEG   = 6;
   localparam int EV_DOWN   = 4;
endpackage

// File: rtl/mgmt_phy_link_track.sv
module mgmt_phy_link_track (
   input  logic clk,
   input  logic rst_n,
   input  logic link_up,
   output logic link_apply
);
   logic link_q;
   logic pend_q;

   // pend_q forces one application of the link state after reset
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         link_q <= 1'b0;
         pend_q <= 1'b1;
      end else begin
         link_q <= link_up;
         pend_q <= 1'b0;
      end
   end

   assign link_apply = pend_q | (link_up ^ link_q);
endmodule

// File: rtl/mgmt_phy_reg_file.sv
module mgmt_phy_reg_file
   import mgmt_phy_pkg::*;
#(
   parameter int EVT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  phy_idx_t         wr_idx,
   input  phy_word_t        wr_data,
   input  logic             rd_clr,
   input  logic             link_apply,
   input  logic             link_up,
   output phy_word_t        ctrl_q,
   output phy_word_t        stat_q,
   output phy_word_t        adv_q,
   output logic [EVT_W-1:0] mask_q,
   output logic [EVT_W-1:0] flags_q
);
   phy_word_t        ctrl_n, stat_n, adv_n;
   logic [EVT_W-1:0] mask_n, flags_n;
   logic             soft_rst;

   always_comb begin
      ctrl_n   = ctrl_q;
      stat_n   = stat_q;
      adv_n    = adv_q;
      mask_n   = mask_q;
      flags_n  = flags_q;
      soft_rst = 1'b0;
      if (rd_clr) flags_n = '0;
      if (wr_en) begin
         case (wr_idx)
            RA_CTRL: begin
               if (wr_data[CTRL_SOFT_RST_BIT]) begin
                  soft_rst = 1'b1;
                  ctrl_n   = CTRL_INIT;
                  stat_n   = STAT_INIT;
                  adv_n    = ADV_INIT;
                  mask_n   = '0;
                  flags_n  = '0;
               end else begin
                  ctrl_n = wr_data & CTRL_WMASK;
                  if (wr_data[CTRL_ANEG_EN_BIT]) stat_n = stat_n | STAT_ANEG;
               end
            end
            RA_ADV:    adv_n  = (wr_data & ADV_WMASK) | ADV_FORCE;
            RA_EVMASK: mask_n = wr_data[EVT_W-1:0];
            default: ;
         endcase
      end
      // link state applied last so its events survive a clear or reset
      if (link_apply || soft_rst) begin
         if (link_up) begin
            stat_n             = stat_n | STAT_LINK;
            flags_n[EV_ENERGY] = 1'b1;
            flags_n[EV_ANEG]   = 1'b1;
         end else begin
            stat_n           = stat_n & ~STAT_LINK;
            flags_n[EV_DOWN] = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q  <= CTRL_INIT;
         stat_q  <= STAT_INIT;
         adv_q   <= ADV_INIT;
         mask_q  <= '0;
         flags_q <= '0;
      end else begin
         ctrl_q  <= ctrl_n;
         stat_q  <= stat_n;
         adv_q   <= adv_n;
         mask_q  <= mask_n;
         flags_q <= flags_n;
      end
   end
endmodule

// File: rtl/mgmt_phy_read_mux.sv
module mgmt_phy_read_mux
   import mgmt_phy_pkg::*;
#(
   parameter int EVT_W = 8
) (
   input  logic             in_range,
   input  phy_idx_t         idx,
   input  phy_word_t        ctrl_q,
   input  phy_word_t        stat_q,
   input  phy_word_t        adv_q,
   input  logic [EVT_W-1:0] mask_q,
   input  logic [EVT_W-1:0] flags_q,
   output phy_word_t        rd_val
);
   always_comb begin
      rd_val = '0;
      if (in_range) begin
         case (idx)
            RA_CTRL:    rd_val = ctrl_q;
            RA_STAT:    rd_val = stat_q;
            RA_ID_HI:   rd_val = ID_HI_VAL;
            RA_ID_LO:   rd_val = ID_LO_VAL;
            RA_ADV:     rd_val = adv_q;
            RA_PARTNER: rd_val = PARTNER_VAL;
            RA_EXPAND:  rd_val = EXPAND_VAL;
            RA_EVENT:   rd_val = PHY_W'(flags_q);
            RA_EVMASK:  rd_val = PHY_W'(mask_q);
            default:    rd_val = '0;
         endcase
      end
   end
endmodule

// File: rtl/mgmt_phy_regs.sv
module mgmt_phy_regs
   import mgmt_phy_pkg::*;
#(
   parameter int FRAME_W  = 32,
   parameter int ADDR_W   = 10,
   parameter int ADDR_LSB = 18,
   parameter int OP_BIT   = 29,
   parameter int EVT_W    = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               frame_we,
   input  logic [FRAME_W-1:0] frame_wdata,
   output logic [FRAME_W-1:0] frame_rdata,
   input  logic               link_up,
   output logic               irq,
   output logic               mgmt_done
);
   localparam int ADDR_MSB = ADDR_LSB + ADDR_W - 1;

   // elaboration-time parameter checks
   if (FRAME_W <= PHY_W) begin : g_bad_frame
      $error("FRAME_W must exceed the PHY register width");
   end
   if (ADDR_W < IDX_W) begin : g_bad_addr
      $error("ADDR_W must cover the register index");
   end
   if (ADDR_LSB < PHY_W || ADDR_MSB >= FRAME_W) begin : g_bad_field
      $error("address field must sit above the data field inside the frame");
   end
   if (OP_BIT >= FRAME_W || OP_BIT < PHY_W ||
       (OP_BIT >= ADDR_LSB && OP_BIT <= ADDR_MSB)) begin : g_bad_op
      $error("OP_BIT must lie outside the data and address fields");
   end
   if (EVT_W < EV_ENERGY + 1 || EVT_W > PHY_W) begin : g_bad_evt
      $error("EVT_W must hold the event bits and fit a PHY register");
   end

   logic [ADDR_W-1:0] acc_addr;
   logic              addr_high;
   logic              in_range;
   phy_idx_t          idx;
   logic              is_rd;
   logic              acc_wr;
   logic              rd_flags_clr;
   logic              link_apply;
   phy_word_t         rd_val;
   phy_word_t         ctrl_q, stat_q, adv_q;
   logic [EVT_W-1:0]  mask_q, flags_q;
   logic [FRAME_W-1:0] frame_q;
   logic              done_q;

   assign acc_addr = frame_wdata[ADDR_LSB +: ADDR_W];

   // upper-address detection only exists when the field is wider than the index
   if (ADDR_W > IDX_W) begin : g_addr_wide
      assign addr_high = |acc_addr[ADDR_W-1:IDX_W];
   end else begin : g_addr_exact
      assign addr_high = 1'b0;
   end

   assign in_range     = ~addr_high;
   assign idx          = acc_addr[IDX_W-1:0];
   assign is_rd        = frame_wdata[OP_BIT];
   assign acc_wr       = frame_we & ~is_rd & in_range;
   assign rd_flags_clr = frame_we & is_rd & in_range & (idx == RA_EVENT);

   mgmt_phy_link_track u_link (
      .clk        (clk),
      .rst_n      (rst_n),
      .link_up    (link_up),
      .link_apply (link_apply)
   );

   mgmt_phy_reg_file #(.EVT_W(EVT_W)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (acc_wr),
      .wr_idx     (idx),
      .wr_data    (frame_wdata[PHY_W-1:0]),
      .rd_clr     (rd_flags_clr),
      .link_apply (link_apply),
      .link_up    (link_up),
      .ctrl_q     (ctrl_q),
      .stat_q     (stat_q),
      .adv_q      (adv_q),
      .mask_q     (mask_q),
      .flags_q    (flags_q)
   );

   mgmt_phy_read_mux #(.EVT_W(EVT_W)) u_rmux (
      .in_range (in_range),
      .idx      (idx),
      .ctrl_q   (ctrl_q),
      .stat_q   (stat_q),
      .adv_q    (adv_q),
      .mask_q   (mask_q),
      .flags_q  (flags_q),
      .rd_val   (rd_val)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frame_q <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= frame_we;
         if (frame_we) begin
            if (is_rd) frame_q <= {frame_wdata[FRAME_W-1:PHY_W], rd_val};
            else       frame_q <= frame_wdata;
         end
      end
   end

   assign frame_rdata = frame_q;
   assign mgmt_done   = done_q;
   assign irq         = |(flags_q & mask_q);
endmodule

// File: rtl/mgmt_phy_regs_chk.sv
module mgmt_phy_regs_chk #(
   parameter int FRAME_W  = 32,
   parameter int ADDR_W   = 10,
   parameter int ADDR_LSB = 18,
   parameter int OP_BIT   = 29,
   parameter int EVT_W    = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               frame_we,
   input logic [FRAME_W-1:0] frame_wdata,
   input logic [FRAME_W-1:0] frame_rdata,
   input logic               link_up,
   input logic               irq,
   input logic               mgmt_done,
   input logic               link_apply,
   input logic               rd_flags_clr,
   input logic [15:0]        ctrl_q,
   input logic [15:0]        stat_q,
   input logic [15:0]        adv_q,
   input logic [EVT_W-1:0]   flags_q
);
   logic mask_zero_wr;
   assign mask_zero_wr = frame_we && !frame_wdata[OP_BIT] &&
                         (frame_wdata[ADDR_LSB +: ADDR_W] == ADDR_W'(30)) &&
                         (frame_wdata[7:0] == 8'h00);

   assert_done_after_access_R9: assert property (@(posedge clk) disable iff (!rst_n)
      frame_we |=> mgmt_done);

   assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_we |=> !mgmt_done);

   assert_link_status_R2: assert property (@(posedge clk) disable iff (!rst_n)
      link_apply |=> (stat_q[2] == $past(link_up) && stat_q[5] == ($past(link_up) | stat_q[5])));

   assert_event_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_flags_clr && !link_apply) |=> (flags_q == '0));

   assert_ctrl_write_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_we |=> $stable(ctrl_q));

   assert_adv_forced_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
      adv_q[7]);

   assert_frame_upper_R8: assert property (@(posedge clk) disable iff (!rst_n)
      frame_we |=> (frame_rdata[FRAME_W-1:16] == $past(frame_wdata[FRAME_W-1:16])));

   assert_irq_masked_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
      mask_zero_wr |=> !irq);
endmodule

bind mgmt_phy_regs mgmt_phy_regs_chk #(
   .FRAME_W (FRAME_W),
   .ADDR_W  (ADDR_W),
   .ADDR_LSB(ADDR_LSB),
   .OP_BIT  (OP_BIT),
   .EVT_W   (EVT_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .frame_we     (frame_we),
   .frame_wdata  (frame_wdata),
   .frame_rdata  (frame_rdata),
   .link_up      (link_up),
   .irq          (irq),
   .mgmt_done    (mgmt_done),
   .link_apply   (link_apply),
   .rd_flags_clr (rd_flags_clr),
   .ctrl_q       (ctrl_q),
   .stat_q       (stat_q),
   .adv_q        (adv_q),
   .flags_q      (flags_q)
);

// File: tb/mgmt_phy_regs_test.sv
module mgmt_phy_regs_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        frame_we = 1'b0;
   logic [31:0] frame_wdata = '0;
   logic [31:0] frame_rdata;
   logic        link_up = 1'b1;
   logic        irq;
   logic        mgmt_done;

   int n_checks = 0;
   int n_errs   = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   mgmt_phy_regs uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .frame_we    (frame_we),
      .frame_wdata (frame_wdata),
      .frame_rdata (frame_rdata),
      .link_up     (link_up),
      .irq         (irq),
      .mgmt_done   (mgmt_done)
   );

   // {req[3:0], read, addr[9:0], wdata[15:0], expected low half[15:0]}
   localparam int NV = 27;
   localparam logic [46:0] VEC [NV] = '{
      {4'd3, 1'b1, 10'd2,   16'h0000, 16'h0007},  // R3 identification
      {4'd3, 1'b1, 10'd3,   16'h0000, 16'hC0D1},
      {4'd3, 1'b1, 10'd5,   16'h0000, 16'h0F71},
      {4'd3, 1'b1, 10'd6,   16'h0000, 16'h0001},
      {4'd1, 1'b1, 10'd0,   16'h0000, 16'h3000},  // R1 reset values, link up applied
      {4'd1, 1'b1, 10'd1,   16'h0000, 16'h782D},
      {4'd1, 1'b1, 10'd4,   16'h0000, 16'h01E1},
      {4'd1, 1'b1, 10'd30,  16'h0000, 16'h0000},
      {4'd6, 1'b0, 10'd4,   16'hFFFF, 16'hFFFF},  // R6 advertisement masking
      {4'd6, 1'b1, 10'd4,   16'h0000, 16'h2DFF},
      {4'd6, 1'b0, 10'd4,   16'h0000, 16'h0000},
      {4'd6, 1'b1, 10'd4,   16'h0000, 16'h0080},
      {4'd6, 1'b0, 10'd30,  16'h1234, 16'h1234},  // R6 enable mask
      {4'd6, 1'b1, 10'd30,  16'h0000, 16'h0034},
      {4'd5, 1'b0, 10'd0,   16'h1100, 16'h1100},  // R5 control mask
      {4'd5, 1'b1, 10'd0,   16'h0000, 16'h1100},
      {4'd7, 1'b0, 10'd17,  16'hABCD, 16'hABCD},  // R7 undecoded
      {4'd7, 1'b1, 10'd17,  16'h0000, 16'h0000},
      {4'd7, 1'b1, 10'd18,  16'h0000, 16'h0000},
      {4'd7, 1'b1, 10'd27,  16'h0000, 16'h0000},
      {4'd7, 1'b1, 10'd31,  16'h0000, 16'h0000},
      {4'd7, 1'b1, 10'd9,   16'h0000, 16'h0000},
      {4'd7, 1'b1, 10'd100, 16'h0000, 16'h0000},
      {4'd7, 1'b0, 10'd62,  16'h00FF, 16'h00FF},  // would alias onto 30
      {4'd7, 1'b1, 10'd30,  16'h0000, 16'h0034},
      {4'd4, 1'b1, 10'd29,  16'h0000, 16'h00C0},  // R4 read-to-clear
      {4'd4, 1'b1, 10'd29,  16'h0000, 16'h0000}
   };

   function automatic logic [31:0] mk(input logic rd, input logic [9:0] a, input logic [15:0] d);
      return {2'b00, rd, 1'b0, a, 2'b00, d};
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errs++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic xfer(input logic [31:0] w, output logic [31:0] r);
      @(negedge clk);
      frame_we    = 1'b1;
      frame_wdata = w;
      @(negedge clk);
      frame_we = 1'b0;
      r = frame_rdata;
      check("R9 done after access", {31'd0, mgmt_done}, 32'd1);
   endtask

   task automatic set_link(input logic v);
      @(negedge clk);
      link_up = v;
      @(negedge clk);
   endtask

   initial begin
      logic [31:0] r;
      repeat (3) @(negedge clk);
      // reset state
      check("R8 frame word in reset", frame_rdata, 32'h0);
      check("R9 done low in reset", {31'd0, mgmt_done}, 32'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check("R10 irq low with enables cleared (R1)", {31'd0, irq}, 32'd0);

      for (int i = 0; i < NV; i++) begin
         xfer(mk(VEC[i][42], VEC[i][41:32], VEC[i][31:16]), r);
         n_checks++;
         if (r[15:0] !== VEC[i][15:0]) begin
            n_errs++;
            $display("FAIL R%0d vector %0d actual=%h expected=%h", VEC[i][46:43], i, r[15:0], VEC[i][15:0]);
         end
      end
      @(negedge clk);
      check("R9 done drops after one cycle", {31'd0, mgmt_done}, 32'd0);

      // link down with enable 0x34 includes bit 4
      set_link(1'b0);
      check("R10 irq on enabled link-down event", {31'd0, irq}, 32'd1);
      xfer(mk(1'b1, 10'd1, 16'h0), r);
      check("R2 status after link down", {16'h0, r[15:0]}, 32'h7809);
      xfer(mk(1'b1, 10'd29, 16'h0), r);
      check("R4 link-down event read", {16'h0, r[15:0]}, 32'h0010);
      check("R10 irq clears with events", {31'd0, irq}, 32'd0);

      // enables off then link up
      xfer(mk(1'b0, 10'd30, 16'h0000), r);
      set_link(1'b1);
      check("R10 irq masked off", {31'd0, irq}, 32'd0);
      xfer(mk(1'b0, 10'd30, 16'h0080), r);
      check("R10 irq after enabling bit 7", {31'd0, irq}, 32'd1);
      xfer(mk(1'b1, 10'd1, 16'h0), r);
      check("R2 status after link up", {16'h0, r[15:0]}, 32'h782D);

      // same-cycle event read and link change
      @(negedge clk);
      link_up     = 1'b0;
      frame_we    = 1'b1;
      frame_wdata = mk(1'b1, 10'd29, 16'h0);
      @(negedge clk);
      frame_we = 1'b0;
      check("R4 read returns prior events", {16'h0, frame_rdata[15:0]}, 32'h00C0);
      xfer(mk(1'b1, 10'd29, 16'h0), r);
      check("R4 same-cycle event survives clear", {16'h0, r[15:0]}, 32'h0010);

      // soft reset with link down
      xfer(mk(1'b0, 10'd0, 16'h8000), r);
      xfer(mk(1'b1, 10'd0, 16'h0), r);
      check("R5 soft reset control", {16'h0, r[15:0]}, 32'h3000);
      xfer(mk(1'b1, 10'd1, 16'h0), r);
      check("R5 soft reset status link down (R1)", {16'h0, r[15:0]}, 32'h7809);
      xfer(mk(1'b1, 10'd4, 16'h0), r);
      check("R5 soft reset advertisement", {16'h0, r[15:0]}, 32'h01E1);
      xfer(mk(1'b1, 10'd30, 16'h0), r);
      check("R5 soft reset enables", {16'h0, r[15:0]}, 32'h0000);
      xfer(mk(1'b1, 10'd29, 16'h0), r);
      check("R5 soft reset applies link down", {16'h0, r[15:0]}, 32'h0010);

      // bit 12 sets status bit 5 even with link down
      xfer(mk(1'b0, 10'd0, 16'h1000), r);
      xfer(mk(1'b1, 10'd1, 16'h0), r);
      check("R5 auto-negotiation enable sets status bit 5", {16'h0, r[15:0]}, 32'h7829);
      xfer(mk(1'b1, 10'd0, 16'h0), r);
      check("R5 control after bit-12 write", {16'h0, r[15:0]}, 32'h1000);

      // upper frame bits
      xfer(32'hF00C_5555, r);
      check("R8 read merges into low half", r, 32'hF00C_C0D1);
      xfer(32'h500C_1234, r);
      check("R8 write keeps written word", r, 32'h500C_1234);
      xfer(mk(1'b1, 10'd3, 16'h0), r);
      check("R3 identification ignores writes", {16'h0, r[15:0]}, 32'h0000C0D1);

      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errs);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_errs++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("CHECKS %0d ERRORS %0d", n_checks, n_errs);
         $finish;
      end
   end
endmodule